// File: doc/BRIEF.md
# Power-Gated Pulse Burst Sequencer

This block runs one fixed, cycle-exact sequence each time it sees a single-cycle start strobe. It first turns on a transmitter power enable, waits a short settling lead, sends a burst of exactly two pulses on the transmit line at a period chosen through an input value, keeps power on for a fixed tail, turns power off, and then raises a single-cycle completion strobe.

The period input is captured when the strobe is accepted, so software or upstream logic may change it freely while a burst is running. The block takes no new strobe until the sequence ends. It is meant to drive an acoustic or similar transmitter, where the power rail has to be up before the first pulse and stay up briefly after the last.

Cycle numbering used below: cycle 0 is the clock cycle in which the accepted start strobe is high, and cycle k is the k-th cycle after it. Pe is the effective period and H = Pe/2 rounded down, but never less than 1.

Top module: `power_burst_seq`

## Requirements
- R1: While reset is high, and in the first cycle after a reset edge, pwr_o, tx_o and complete_o are all low and the block is idle. A reset during a sequence ends it.
- R2: pwr_o goes high in cycle 3 and is low in cycles 1 and 2.
- R3: tx_o is never high while pwr_o is low. tx_o is low in cycles 3 and 4.
- R4: Exactly two tx_o pulses occur per sequence. They start in cycle 5 and in cycle 5+Pe.
- R5: Each tx_o pulse stays high for exactly H cycles.
- R6: pwr_o stays high through cycle 9+2*Pe and is low from cycle 10+2*Pe on. This is five cycles after the burst window of 2*Pe cycles starting at cycle 5 closes.
- R7: complete_o is high for exactly one cycle, cycle 12+2*Pe, with pwr_o low. It is low at all other times.
- R8: The period input is sampled only in cycle 0. Changing it later in the sequence has no effect on the outputs.
- R9: A start strobe in any of cycles 1 to 12+2*Pe is ignored. A strobe in cycle 13+2*Pe or later begins a new sequence.
- R10: A period input value of 0 or 1 is treated as Pe = 2. Any other value is used as given, so Pe = period_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Single-cycle start strobe |
| period_i | input | PW (8) | Requested pulse period in clock cycles |
| pwr_o | output | 1 | Transmitter power enable |
| tx_o | output | 1 | Transmit pulse output |
| complete_o | output | 1 | Single-cycle completion strobe |

## Verification
All outputs are decoded from registered state, so each result falls in a known cycle k after the accepted strobe. pwr_o rises at k=3. The pulses begin at k=5 and k=5+Pe. pwr_o falls at k=10+2*Pe and complete_o is due at k=12+2*Pe. The bench drives every input on the falling edge and samples the outputs on the same falling edge before it drives, so the value it reads is exactly cycle k. It compares all three outputs against a timeline computed from Pe in every cycle of every sequence. The busy-strobe, period-change and back-to-back cases are placed on chosen values of k, including the completion cycle and the first idle cycle.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEAD  = 3'd1,
        ST_GAP   = 3'd2,
        ST_BURST = 3'd3,
        ST_TAIL  = 3'd4,
        ST_QUIET = 3'd5,
        ST_DONE  = 3'd6
    } seq_state_e;

    typedef struct packed {
        logic pwr;
        logic done;
        logic burst;
    } seq_out_t;

    function automatic seq_out_t decode_state(seq_state_e s);
        seq_out_t o;
        o.pwr   = (s == ST_GAP) || (s == ST_BURST) || (s == ST_TAIL);
        o.done  = (s == ST_DONE);
        o.burst = (s == ST_BURST);
        return o;
    endfunction

endpackage

// File: rtl/bsq_period_latch.sv
module bsq_period_latch #(
    parameter int PW    = 8,
    parameter int MIN_P = 2
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          load_i,
    input  logic [PW-1:0] period_i,
    output logic [PW-1:0] period_o,
    output logic [PW-1:0] high_o
);
    localparam logic [PW-1:0] MinP = PW'(MIN_P);

    logic [PW-1:0] clamped;
    logic [PW-1:0] half;

    always_comb begin
        clamped = (period_i < MinP) ? MinP : period_i;
        half    = clamped >> 1;
        if (half == '0) half = PW'(1);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            period_o <= MinP;
            high_o   <= PW'(1);
        end else if (load_i) begin
            period_o <= clamped;
            high_o   <= half;
        end
    end

    // R10: the held period never falls below the floor
    a_r10_period_floor: assert property (@(posedge clk_i) disable iff (rst_i)
        period_o >= MinP);

    // R5: the high time is never zero and never the whole period
    a_r5_high_inside_period: assert property (@(posedge clk_i) disable iff (rst_i)
        (high_o != '0) && (high_o < period_o));

    // R8: held values only move on a load
    a_r8_hold_without_load: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(load_i) && !$past(rst_i) |-> $stable(period_o));

endmodule

// File: rtl/bsq_phase_timer.sv
module bsq_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          zero_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign zero_o = (cnt_q == '0);

    // R6: without a load the counter only moves down by one or rests at zero
    a_r6_timer_monotonic: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(load_i) && !$past(rst_i) && $past(cnt_q) != '0 |-> cnt_q == $past(cnt_q) - CW'(1));

endmodule

// File: rtl/bsq_burst_gen.sv
module bsq_burst_gen #(
    parameter int PW     = 8,
    parameter int PULSES = 2
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          run_i,
    input  logic [PW-1:0] period_i,
    input  logic [PW-1:0] high_i,
    output logic          tx_o,
    output logic          last_o
);
    localparam int NW = (PULSES > 1) ? $clog2(PULSES) : 1;
    localparam logic [NW-1:0] LastIdx = NW'(PULSES - 1);

    logic [PW-1:0] pos_q;
    logic [NW-1:0] idx_q;
    logic          wrap;

    assign wrap = (pos_q == period_i - PW'(1));

    always_ff @(posedge clk_i) begin
        if (rst_i || !run_i) begin
            pos_q <= '0;
            idx_q <= '0;
        end else if (wrap) begin
            pos_q <= '0;
            idx_q <= idx_q + NW'(1);
        end else begin
            pos_q <= pos_q + PW'(1);
        end
    end

    assign tx_o   = run_i && (pos_q < high_i);
    assign last_o = run_i && wrap && (idx_q == LastIdx);

    // checker state: pulses seen this run and width of the current pulse
    logic [NW:0]   chk_pulses;
    logic [PW-1:0] chk_width;
    logic          tx_d;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            chk_pulses <= '0;
            chk_width  <= '0;
            tx_d       <= 1'b0;
        end else begin
            tx_d <= tx_o;
            if (!run_i) chk_pulses <= '0;
            else if (tx_o && !tx_d) chk_pulses <= chk_pulses + (NW+1)'(1);
            chk_width <= tx_o ? chk_width + PW'(1) : '0;
        end
    end

    // R4: never more than the set number of pulses within one burst
    a_r4_pulse_limit: assert property (@(posedge clk_i) disable iff (rst_i)
        chk_pulses <= (NW+1)'(PULSES));

    // R4: when the burst closes, exactly the set number of pulses were sent
    a_r4_pulse_count_at_end: assert property (@(posedge clk_i) disable iff (rst_i)
        last_o |-> chk_pulses == (NW+1)'(PULSES));

    // R5: every pulse ends after exactly the high time
    a_r5_pulse_width: assert property (@(posedge clk_i) disable iff (rst_i)
        tx_d && !tx_o |-> chk_width == high_i);

endmodule

// File: rtl/bsq_seq_fsm.sv
module bsq_seq_fsm
    import bsq_pkg::*;
#(
    parameter int LEAD_CYC  = 3,
    parameter int GAP_CYC   = 2,
    parameter int TAIL_CYC  = 5,
    parameter int QUIET_CYC = 2,
    parameter int CW        = 4
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          start_i,
    input  logic          timer_zero_i,
    input  logic          burst_last_i,
    output logic          accept_o,
    output logic          timer_load_o,
    output logic [CW-1:0] timer_val_o,
    output seq_state_e    state_o
);
    // the start cycle itself is cycle 0, so the lead state spans LEAD_CYC-1 cycles
    localparam logic [CW-1:0] LeadLoad  = CW'(LEAD_CYC - 2);
    localparam logic [CW-1:0] GapLoad   = CW'(GAP_CYC - 1);
    localparam logic [CW-1:0] TailLoad  = CW'(TAIL_CYC - 1);
    localparam logic [CW-1:0] QuietLoad = CW'(QUIET_CYC - 1);

    seq_state_e state_q, state_d;

    always_comb begin
        state_d      = state_q;
        timer_load_o = 1'b0;
        timer_val_o  = '0;
        accept_o     = 1'b0;
        unique case (state_q)
            ST_IDLE: if (start_i) begin
                accept_o     = 1'b1;
                state_d      = ST_LEAD;
                timer_load_o = 1'b1;
                timer_val_o  = LeadLoad;
            end
            ST_LEAD: if (timer_zero_i) begin
                state_d      = ST_GAP;
                timer_load_o = 1'b1;
                timer_val_o  = GapLoad;
            end
            ST_GAP: if (timer_zero_i) state_d = ST_BURST;
            ST_BURST: if (burst_last_i) begin
                state_d      = ST_TAIL;
                timer_load_o = 1'b1;
                timer_val_o  = TailLoad;
            end
            ST_TAIL: if (timer_zero_i) begin
                state_d      = ST_QUIET;
                timer_load_o = 1'b1;
                timer_val_o  = QuietLoad;
            end
            ST_QUIET: if (timer_zero_i) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= ST_IDLE;
        else       state_q <= state_d;
    end

    assign state_o = state_q;

    // R9: a strobe while busy never restarts the lead phase
    a_r9_busy_start_ignored: assert property (@(posedge clk_i) disable iff (rst_i)
        start_i && state_q != ST_IDLE && state_q != ST_LEAD |=> state_q != ST_LEAD);

    // R1: the first cycle after reset is idle
    a_r1_reset_idle: assert property (@(posedge clk_i)
        $past(rst_i) |-> state_q == ST_IDLE);

    // R7: the done state lasts one cycle and is followed by idle
    a_r7_done_single: assert property (@(posedge clk_i) disable iff (rst_i)
        state_q == ST_DONE |=> state_q == ST_IDLE);

endmodule

// File: rtl/power_burst_seq.sv
module power_burst_seq
    import bsq_pkg::*;
#(
    parameter int PW        = 8,
    parameter int PULSES    = 2,
    parameter int LEAD_CYC  = 3,
    parameter int GAP_CYC   = 2,
    parameter int TAIL_CYC  = 5,
    parameter int QUIET_CYC = 2,
    parameter int MIN_P     = 2
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          start_i,
    input  logic [PW-1:0] period_i,
    output logic          pwr_o,
    output logic          tx_o,
    output logic          complete_o
);
    localparam int MAXC = (LEAD_CYC > TAIL_CYC) ? LEAD_CYC : TAIL_CYC;
    localparam int CW   = $clog2(MAXC + 1) + 1;

    seq_state_e    state;
    seq_out_t      dec;
    logic          accept;
    logic          t_load;
    logic [CW-1:0] t_val;
    logic          t_zero;
    logic          b_last;
    logic          b_tx;
    logic [PW-1:0] per_q;
    logic [PW-1:0] high_q;

    bsq_seq_fsm #(
        .LEAD_CYC (LEAD_CYC),
        .GAP_CYC  (GAP_CYC),
        .TAIL_CYC (TAIL_CYC),
        .QUIET_CYC(QUIET_CYC),
        .CW       (CW)
    ) u_fsm (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .start_i     (start_i),
        .timer_zero_i(t_zero),
        .burst_last_i(b_last),
        .accept_o    (accept),
        .timer_load_o(t_load),
        .timer_val_o (t_val),
        .state_o     (state)
    );

    bsq_phase_timer #(.CW(CW)) u_timer (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .load_i    (t_load),
        .load_val_i(t_val),
        .zero_o    (t_zero)
    );

    bsq_period_latch #(.PW(PW), .MIN_P(MIN_P)) u_per (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .load_i  (accept),
        .period_i(period_i),
        .period_o(per_q),
        .high_o  (high_q)
    );

    assign dec = decode_state(state);

    bsq_burst_gen #(.PW(PW), .PULSES(PULSES)) u_burst (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .run_i   (dec.burst),
        .period_i(per_q),
        .high_i  (high_q),
        .tx_o    (b_tx),
        .last_o  (b_last)
    );

    assign pwr_o      = dec.pwr;
    assign tx_o       = b_tx;
    assign complete_o = dec.done;

    // R3: transmit only with power up
    a_r3_tx_inside_power: assert property (@(posedge clk_i) disable iff (rst_i)
        tx_o |-> pwr_o);

    // R7: completion strobe is one cycle wide and comes with power off
    a_r7_complete_single: assert property (@(posedge clk_i) disable iff (rst_i)
        complete_o |=> !complete_o);
    a_r7_complete_power_off: assert property (@(posedge clk_i) disable iff (rst_i)
        complete_o |-> !pwr_o && !tx_o);

    // R2: power rises only out of the lead phase
    a_r2_power_after_lead: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(pwr_o) |-> $past(state) == ST_LEAD);

    // R1: outputs quiet right after reset
    a_r1_reset_outputs: assert property (@(posedge clk_i)
        $past(rst_i) |-> !pwr_o && !tx_o && !complete_o);

endmodule

// File: tb/sim_power_burst_seq.sv
module sim_power_burst_seq;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [PW-1:0] period;
    logic          pwr, tx, cmp;

    int errors = 0;
    int checks = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    power_burst_seq u0 (
        .clk_i     (clk),
        .rst_i     (rst),
        .start_i   (start),
        .period_i  (period),
        .pwr_o     (pwr),
        .tx_o      (tx),
        .complete_o(cmp)
    );

    function automatic int eff_period(int p);
        return (p < 2) ? 2 : p;
    endfunction

    function automatic int high_of(int pe);
        return (pe / 2 < 1) ? 1 : pe / 2;
    endfunction

    function automatic bit exp_pwr(int k, int pe);
        return (k >= 3) && (k <= 9 + 2 * pe);
    endfunction

    function automatic bit exp_tx(int k, int pe);
        if (k < 5 || k >= 5 + 2 * pe) return 1'b0;
        return ((k - 5) % pe) < high_of(pe);
    endfunction

    function automatic bit exp_cmp(int k, int pe);
        return k == 12 + 2 * pe;
    endfunction

    task automatic check_bit(string req, string scn, int k, logic act, logic expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s [%s] cycle %0d: actual=%b expected=%b", req, scn, k, act, expv);
        end
    endtask

    // We are at a falling edge. Start strobe this cycle, then check every cycle.
    // busy_k: cycle in which a stray strobe is driven (0 = none)
    // chg_k : cycle in which period input is changed (0 = none)
    task automatic run_seq(int p, int busy_k, int chg_k, string scn);
        int pe;
        int last;
        pe = eff_period(p);
        last = 12 + 2 * pe;
        period = PW'(p);
        start = 1'b1;
        for (int k = 1; k <= last; k++) begin
            @(negedge clk);
            start = 1'b0;
            check_bit((k < 5) ? "R2" : "R6", scn, k, pwr, exp_pwr(k, pe));
            check_bit((k < 5) ? "R3" : ((k >= 5 + pe) ? "R4" : "R5"), scn, k, tx, exp_tx(k, pe));
            check_bit("R7", scn, k, cmp, exp_cmp(k, pe));
            if (k == busy_k) start = 1'b1;
            if (k == chg_k) period = PW'($urandom_range(0, 255));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1;
        start = 1'b0;
        period = 8'd6;
        repeat (3) @(negedge clk);
        // R1: outputs low under reset
        check_bit("R1", "reset", 0, pwr, 1'b0);
        check_bit("R1", "reset", 0, tx, 1'b0);
        check_bit("R1", "reset", 0, cmp, 1'b0);
        // R1: a strobe during reset starts nothing
        start = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        start = 1'b0;
        repeat (4) @(negedge clk);
        check_bit("R1", "reset", 4, pwr, 1'b0);

        // directed periods, R10 clamp of 0 and 1
        run_seq(0, 0, 0, "R10 p0");
        @(negedge clk);
        run_seq(1, 0, 0, "R10 p1");
        @(negedge clk);
        run_seq(2, 0, 0, "p2");
        @(negedge clk);
        run_seq(3, 0, 0, "p3 odd");
        @(negedge clk);
        // R8: period change in cycle 2 and later has no effect
        run_seq(7, 0, 2, "R8 change");
        @(negedge clk);
        // R9: stray strobes during lead, burst, and in the completion cycle
        run_seq(4, 1, 0, "R9 lead");
        @(negedge clk);
        run_seq(5, 9, 0, "R9 burst");
        @(negedge clk);
        run_seq(6, 24, 0, "R9 done cycle");
        // R9: back to back, first idle cycle accepts a new strobe
        @(negedge clk);
        check_bit("R9", "idle", 0, pwr, 1'b0);
        run_seq(9, 0, 0, "R9 back-to-back");
        @(negedge clk);
        run_seq(255, 0, 0, "p255");
        repeat (3) @(negedge clk);

        // random mix
        for (int i = 0; i < 30; i++) begin
            int p;
            int pe;
            int bk;
            p = int'($urandom_range(0, 40));
            pe = eff_period(p);
            bk = ($urandom_range(0, 1) == 1) ? int'($urandom_range(1, 12 + 2 * pe)) : 0;
            run_seq(p, bk, ($urandom_range(0, 1) == 1) ? 3 : 0, "random R8 R9");
            repeat ($urandom_range(1, 3)) @(negedge clk);
        end

        // R1: reset in the middle of a burst ends it
        period = 8'd10;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (7) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_bit("R1", "mid reset", 0, pwr, 1'b0);
        check_bit("R1", "mid reset", 0, tx, 1'b0);
        repeat (30) begin
            @(negedge clk);
            check_bit("R1", "after mid reset", 0, pwr | tx | cmp, 1'b0);
        end
        @(negedge clk);
        run_seq(2, 0, 0, "after reset");

        done_flag = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule